// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This unit holds a group of `N_PART` participants at a rendezvous point until every one of them has arrived. A participant signals arrival with a one-cycle pulse on its own arrive line. Its release line then drops and stays low until the whole group has checked in. The arrival that completes the group frees everyone in the same clock edge.

The barrier is reusable without being re-armed. Each participant owns a private sense bit, and that bit inverts whenever one of its arrivals is accepted. The unit keeps a single shared release-sense bit. When the group completes, the shared bit takes the new private sense of the final arrivals. A participant is waiting exactly while its private sense differs from the shared bit. The shared bit is never cleared between episodes; it simply flips once per episode. A quick participant that re-enters the next episode therefore cannot withdraw a release that a slow participant has not yet acted upon. The quick one just waits until the slow one arrives again.

Arrivals from several participants in one cycle are all counted in that cycle. An arrive pulse from a participant that is already waiting is dropped.

Top module: `sense_barrier`

## Requirements
- R1: After reset, and after any later reset, every `release_o` bit is 1 (nobody waiting) and `gsense_o` is 0.
- R2: An arrive pulse from a free participant, which leaves the group still incomplete, clears that participant's `release_o` bit from the next cycle on.
- R3: No participant's `release_o` bit returns to 1 unless `gsense_o` changes in the same cycle, that is, unless the group has completed.
- R4: The cycle after the accepted arrivals bring the total to `N_PART`, every `release_o` bit is 1 and `gsense_o` has inverted.
- R5: Arrive pulses on several participants in the same cycle are all counted in that cycle; pulses from all `N_PART` at once complete the group immediately.
- R6: An arrive pulse from a participant whose `release_o` bit is 0 is ignored: its bit stays 0 and the pulse does not count towards completion.
- R7: `gsense_o` keeps its value in every cycle in which the group does not complete; it is never cleared between episodes.
- R8: A participant that re-enters after a release waits until every other participant, including one that has not yet re-entered, arrives again. The slow participant's `release_o` bit stays 1 meanwhile.
- R9: The internal arrival count never reaches `N_PART`; it returns to 0 in the completing cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | N_PART | One-cycle arrival pulse per participant |
| release_o | output | N_PART | 1 = participant free to proceed, 0 = held at the barrier |
| gsense_o | output | 1 | Shared release-sense bit, inverts once per completed episode |

## Verification
The assertions assume that each arrive line is a synchronous pulse sampled on the rising edge. They also assume that a participant may pulse at any time, including while it is held. The stimulus changes `arrive_i` only on falling edges and deliberately sends pulses from held participants. The release-rise check relies on the shared sense moving only when the group completes. The vector walk therefore includes episodes in which a slow participant stays free while others re-enter, and a completion in which held pulses arrive together with the final accepted one.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int unsigned SB_MAX_PART = 64;

   function automatic int unsigned sb_popcount(input logic [SB_MAX_PART-1:0] v);
      int unsigned n;
      n = 0;
      for (int k = 0; k < SB_MAX_PART; k++) n += int'(v[k]);
      return n;
   endfunction
endpackage

// File: rtl/sb_sense_slot.sv
module sb_sense_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic arrive_i,
   input  logic gsense_i,
   output logic accept_o,
   output logic free_o
);
   logic lsense_q;
   logic held;

   assign held     = lsense_q ^ gsense_i;
   assign free_o   = ~held;
   assign accept_o = arrive_i & ~held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lsense_q <= 1'b0;
      else        lsense_q <= lsense_q ^ accept_o;
   end

   // R6: a pulse from a held participant leaves its sense alone
   p_held_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arrive_i && held) |=> (lsense_q == $past(lsense_q)));
   // R2: an accepted arrival inverts the local sense
   p_accept_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arrive_i && !held) |=> (lsense_q != $past(lsense_q)));
endmodule

// File: rtl/sb_arrival_tally.sv
module sb_arrival_tally #(
   parameter int unsigned N_PART = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PART-1:0] accept_i,
   output logic              gsense_o,
   output logic              done_o
);
   import sb_pkg::*;

   localparam int unsigned CW = $clog2(N_PART + 1);
   localparam int unsigned SW = CW + 1;

   logic [CW-1:0] count_q;
   logic [SW-1:0] sum;
   logic          gsense_q;

   always_comb begin
      sum    = SW'(count_q) + SW'(sb_popcount(SB_MAX_PART'(accept_i)));
      done_o = (sum == SW'(N_PART));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         gsense_q <= 1'b0;
      end else begin
         count_q  <= done_o ? '0 : CW'(sum);
         gsense_q <= gsense_q ^ done_o;
      end
   end

   assign gsense_o = gsense_q;

   // R9: the count stays below the group size
   p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q < CW'(N_PART));
   // R9: completion empties the count
   p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (count_q == '0));
   // R4: completion inverts the shared sense
   p_flip_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (gsense_q != $past(gsense_q)));
   // R7: no completion, no change of the shared sense
   p_sense_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> $stable(gsense_q));
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
   parameter int unsigned N_PART = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PART-1:0] arrive_i,
   output logic [N_PART-1:0] release_o,
   output logic              gsense_o
);
   import sb_pkg::*;

   if (N_PART < 1 || N_PART > SB_MAX_PART) begin : g_bad_size
      $error("sense_barrier: N_PART must lie in 1..%0d", SB_MAX_PART);
   end

   logic [N_PART-1:0] accept;
   logic              gsense;
   logic              done;

   for (genvar g = 0; g < N_PART; g++) begin : g_slot
      sb_sense_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .arrive_i (arrive_i[g]),
         .gsense_i (gsense),
         .accept_o (accept[g]),
         .free_o   (release_o[g])
      );

      // R3: a participant is freed only together with a change of shared sense
      p_hold_until_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (release_o[g] && !$past(release_o[g])) |-> (gsense != $past(gsense)));
   end

   sb_arrival_tally #(.N_PART(N_PART)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .gsense_o (gsense),
      .done_o   (done)
   );

   assign gsense_o = gsense;

   // R4: after completion every participant is free
   p_all_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (release_o == '1));
endmodule

// File: tb/sense_barrier_bench.sv
module sense_barrier_bench;
   localparam int unsigned NP = 4;
   localparam int unsigned NV = 14;

   // vector: {arrive[3:0], expected release[3:0], expected gsense}
   localparam logic [8:0] VEC [NV] = '{
      {4'b0001, 4'b1110, 1'b0},
      {4'b0001, 4'b1110, 1'b0},
      {4'b0110, 4'b1000, 1'b0},
      {4'b0000, 4'b1000, 1'b0},
      {4'b1000, 4'b1111, 1'b1},
      {4'b0001, 4'b1110, 1'b1},
      {4'b0001, 4'b1110, 1'b1},
      {4'b0110, 4'b1000, 1'b1},
      {4'b1000, 4'b1111, 1'b0},
      {4'b1111, 4'b1111, 1'b1},
      {4'b1011, 4'b0100, 1'b1},
      {4'b0100, 4'b1111, 1'b0},
      {4'b1110, 4'b0001, 1'b0},
      {4'b1111, 4'b1111, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] arrive = '0;
   logic [NP-1:0] release_w;
   logic          gsense_w;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   sense_barrier #(.N_PART(NP)) u_sense_barrier (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive_i  (arrive),
      .release_o (release_w),
      .gsense_o  (gsense_w)
   );

   function automatic string vec_tag(int k);
      case (k)
         0:       return "R2";
         1, 6:    return "R6";
         2:       return "R5";
         3:       return "R3";
         4, 8:    return "R4";
         5, 7:    return "R8";
         9:       return "R5";
         10:      return "R2";
         11:      return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [NP-1:0] rel_exp, logic g_exp);
      checks++;
      if (release_w !== rel_exp) begin
         failures++;
         $display("FAIL %s release actual=%b expected=%b", tag, release_w, rel_exp);
      end
      checks++;
      if (gsense_w !== g_exp) begin
         failures++;
         $display("FAIL %s gsense actual=%b expected=%b", tag, gsense_w, g_exp);
      end
   endtask

   task automatic step(logic [NP-1:0] a);
      arrive = a;
      @(negedge clk);
      arrive = '0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", 4'b1111, 1'b0);

      for (int k = 0; k < NV; k++) begin
         step(VEC[k][8:5]);
         check(vec_tag(k), VEC[k][4:1], VEC[k][0]);
      end

      // R7: idle cycles keep shared sense and releases
      repeat (6) @(negedge clk);
      check("R7 idle", 4'b1111, 1'b1);

      // R3: three of four arrive, nobody freed over a long hold
      step(4'b0111);
      repeat (8) @(negedge clk);
      check("R3 hold", 4'b1000, 1'b1);
      // R6: repeated pulses from held participants do not complete the group
      step(4'b0111);
      step(4'b0011);
      check("R6 no complete", 4'b1000, 1'b1);
      step(4'b1000);
      check("R4 complete", 4'b1111, 1'b0);

      // R1: reset in the middle of an episode
      step(4'b0101);
      check("R2 partial", 4'b1010, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mid reset", 4'b1111, 1'b0);
      // after reset the count starts over: three arrivals must not release
      step(4'b0111);
      check("R9 recount", 4'b1000, 1'b0);
      step(4'b1000);
      check("R4 after reset", 4'b1111, 1'b1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule